// File: doc/BRIEF.md
# Hardware Cursor Overlay (64x64, two bit planes)

This block lays a small two-colour cursor over a stream of 24-bit pixels. A display pipeline feeds it the current screen coordinate and the pixel already chosen for that position. One cycle later the block returns either that same pixel or a cursor colour. The cursor shape is 64 by 64 pixels. It is held in an on-block image store of 1024 bytes, split into a source plane and a mask plane. Each plane stores eight bytes per row, and the most significant bit of each byte is the leftmost pixel.

A host programs the block through a write-only register port that is one byte wide. The host loads the image store as a stream of byte writes, and the load address advances by one after each write. The host also writes the cursor position, two cursor colours and a mode field. Both position registers carry a bias of 64. This lets the cursor hang partly off the left or top edge of the screen while every register value stays non-negative.

Top module: `hcur_overlay`

## Requirements
- R1: After synchronous reset, `pix_out` is 0, the mode is off, and the position, colour, colour-pointer and image-load-address registers are all 0.
- R2: When the mode field is not 3, `pix_out` equals the `pix_in` of the previous cycle.
- R3: Every output has exactly one cycle of latency. `scr_x`, `scr_y` and `pix_in` are taken together on the same cycle.
- R4: The image-load address is 10 bits. The index register (offset 0x0) writes bits 7:0. Control bits 3:2 (offset 0x1) write bits 9:8. Each write to the image data port (offset 0x2) stores the byte at that address and then adds one. The address wraps from 1023 to 0, and a carry from bit 7 moves into bit 8.
- R5: Position X is built from the low byte at 0x3 and a 4-bit high nibble at 0x4 (bits 3:0). Y is built the same way from 0x5 and 0x6. Cursor column c and row r (each 0 to 63) appear at screen x = X − 64 + c and y = Y − 64 + r.
- R6: When X or Y is below 64, only the columns or rows that land at screen coordinates of 0 or more are shown. At screen x = 0, the column shown is 64 − X.
- R7: Bytes 0–511 form the source plane and bytes 512–1023 form the mask plane. Pixel (c, r) uses bit 7 − (c mod 8) of byte r·8 + c/8 within each plane.
- R8: In overlay mode, inside the cursor window, a mask bit of 0 passes `pix_in` through. A mask bit of 1 outputs the foreground (entry 2) when the source bit is 1, and the background (entry 1) when it is 0.
- R9: A write to the colour pointer (0x7, bits 1:0) selects an entry and restarts the component order. Each write to the colour data port (0x8) fills red, then green, then blue. After blue, the pointer moves to the next entry. Writes that land on entry 0 or 3 change nothing.
- R10: Mode field values 0, 1 and 2 (control bits 1:0) all pass pixels through. Only 3 enables the overlay.
- R11: In overlay mode, a pixel outside the 64×64 window passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 8 | Host write data |
| scr_x | input | 12 | Screen column of the current pixel |
| scr_y | input | 12 | Screen row of the current pixel |
| pix_in | input | 24 | Underlying pixel {red, green, blue} |
| pix_out | output | 24 | Pixel after cursor substitution, one cycle later |

## Verification
The assertions assume that every host write is a single-cycle strobe with a stable offset and data. They also assume that the coordinates and the pixel arrive on the same cycle, so comparing the output with last cycle's input is meaningful. The bench drives all inputs on the falling edge and raises `host_we` for exactly one cycle per write. It never writes the image store during a window sweep unless it is testing that case on purpose. The reference model applies host writes after it computes the pixel for the same edge, which matches the rule that a register write takes effect on the following cycle.

// File: rtl/hcur_pkg.sv
package hcur_pkg;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    // Host register offsets
    typedef enum logic [3:0] {
        HR_INDEX  = 4'h0,
        HR_CTRL   = 4'h1,
        HR_IMG    = 4'h2,
        HR_XLO    = 4'h3,
        HR_XHI    = 4'h4,
        HR_YLO    = 4'h5,
        HR_YHI    = 4'h6,
        HR_CPTR   = 4'h7,
        HR_CDATA  = 4'h8
    } hreg_e;

    localparam logic [1:0] MODE_OVERLAY = 2'd3;

    function automatic rgb_t put_component(rgb_t c, logic [1:0] phase, logic [7:0] v);
        rgb_t o;
        o = c;
        case (phase)
            2'd0:    o.r = v;
            2'd1:    o.g = v;
            default: o.b = v;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/hcur_regs.sv
module hcur_regs
    import hcur_pkg::*;
#(
    parameter int POS_W = 12,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [3:0]       host_addr,
    input  logic [7:0]       host_wdata,
    output logic             ram_we,
    output logic [AW-1:0]    ram_waddr,
    output logic [7:0]       ram_wdata,
    output logic             overlay_on,
    output logic [POS_W-1:0] xpos,
    output logic [POS_W-1:0] ypos,
    output rgb_t             col_bg,
    output rgb_t             col_fg
);
    localparam int HI_W = AW - 8;

    logic [1:0]    mode;
    logic [AW-1:0] load_addr;
    logic [1:0]    cptr;
    logic [1:0]    cphase;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= '0;
            load_addr <= '0;
            xpos      <= '0;
            ypos      <= '0;
            cptr      <= '0;
            cphase    <= '0;
            col_bg    <= '0;
            col_fg    <= '0;
        end else if (host_we) begin
            case (host_addr)
                HR_INDEX: load_addr[7:0] <= host_wdata;
                HR_CTRL: begin
                    mode               <= host_wdata[1:0];
                    load_addr[AW-1:8]  <= host_wdata[2 +: HI_W];
                end
                HR_IMG:  load_addr <= load_addr + 1'b1;
                HR_XLO:  xpos[7:0] <= host_wdata;
                HR_XHI:  xpos[POS_W-1:8] <= host_wdata[POS_W-9:0];
                HR_YLO:  ypos[7:0] <= host_wdata;
                HR_YHI:  ypos[POS_W-1:8] <= host_wdata[POS_W-9:0];
                HR_CPTR: begin
                    cptr   <= host_wdata[1:0];
                    cphase <= '0;
                end
                HR_CDATA: begin
                    if (cptr == 2'd1) col_bg <= put_component(col_bg, cphase, host_wdata);
                    if (cptr == 2'd2) col_fg <= put_component(col_fg, cphase, host_wdata);
                    if (cphase == 2'd2) begin
                        cphase <= '0;
                        cptr   <= cptr + 1'b1;
                    end else begin
                        cphase <= cphase + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign ram_we     = host_we && (host_addr == HR_IMG);
    assign ram_waddr  = load_addr;
    assign ram_wdata  = host_wdata;
    assign overlay_on = (mode == MODE_OVERLAY);

    // R4: each image write advances the load address by one
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> ram_waddr == $past(ram_waddr) + 1'b1);

    // R4: index write keeps the upper address bits
    a_r4_index_keeps_hi: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == HR_INDEX) |=>
            (ram_waddr[AW-1:8] == $past(ram_waddr[AW-1:8]) && ram_waddr[7:0] == $past(host_wdata)));

    // R9: the pointer moves to the next entry after the blue byte
    a_r9_entry_step: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == HR_CDATA && cphase == 2'd2) |=>
            (cptr == $past(cptr) + 1'b1 && cphase == 2'd0));

endmodule

// File: rtl/hcur_ram.sv
module hcur_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-2:0] plane_addr,
    output logic [7:0]    src_byte,
    output logic [7:0]    msk_byte
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Lower half is the source plane, upper half the mask plane
    assign src_byte = mem[{1'b0, plane_addr}];
    assign msk_byte = mem[{1'b1, plane_addr}];

endmodule

// File: rtl/hcur_mix.sv
module hcur_mix
    import hcur_pkg::*;
#(
    parameter int POS_W = 12,
    parameter int DIM   = 64,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             overlay_on,
    input  logic [POS_W-1:0] xpos,
    input  logic [POS_W-1:0] ypos,
    input  rgb_t             col_bg,
    input  rgb_t             col_fg,
    input  logic [POS_W-1:0] scr_x,
    input  logic [POS_W-1:0] scr_y,
    input  logic [23:0]      pix_in,
    output logic [AW-2:0]    plane_addr,
    input  logic [7:0]       src_byte,
    input  logic [7:0]       msk_byte,
    output logic [23:0]      pix_out
);
    localparam int SW = POS_W + 1;
    localparam int CW = $clog2(DIM);

    logic [SW-1:0] sx, sy, dx, dy;
    logic          in_x, in_y, hit;
    logic [2:0]    bit_sel;
    logic          sbit, mbit;
    logic [23:0]   mixed;

    always_comb begin
        sx   = {1'b0, scr_x} + SW'(DIM);
        sy   = {1'b0, scr_y} + SW'(DIM);
        dx   = sx - {1'b0, xpos};
        dy   = sy - {1'b0, ypos};
        in_x = (sx >= {1'b0, xpos}) && (dx < SW'(DIM));
        in_y = (sy >= {1'b0, ypos}) && (dy < SW'(DIM));
        hit  = in_x && in_y;
    end

    assign plane_addr = {dy[CW-1:0], dx[CW-1:3]};
    assign bit_sel    = 3'd7 - dx[2:0];
    assign sbit       = src_byte[bit_sel];
    assign mbit       = msk_byte[bit_sel];

    always_comb begin
        mixed = pix_in;
        if (overlay_on && hit && mbit) mixed = sbit ? col_fg : col_bg;
    end

    always_ff @(posedge clk) begin
        if (rst) pix_out <= '0;
        else     pix_out <= mixed;
    end

    // R2: bypass when the overlay is off
    a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
        !overlay_on |=> pix_out == $past(pix_in));

    // R11: outside the window the pixel passes
    a_r11_outside: assert property (@(posedge clk) disable iff (rst)
        (overlay_on && !hit) |=> pix_out == $past(pix_in));

    // R8: clear mask passes the pixel
    a_r8_clear_mask: assert property (@(posedge clk) disable iff (rst)
        (overlay_on && hit && !mbit) |=> pix_out == $past(pix_in));

    // R8: set mask with set source gives the foreground
    a_r8_foreground: assert property (@(posedge clk) disable iff (rst)
        (overlay_on && hit && mbit && sbit) |=> pix_out == $past(col_fg));

endmodule

// File: rtl/hcur_overlay.sv
module hcur_overlay
    import hcur_pkg::*;
#(
    parameter int POS_W = 12,
    parameter int DIM   = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [3:0]       host_addr,
    input  logic [7:0]       host_wdata,
    input  logic [POS_W-1:0] scr_x,
    input  logic [POS_W-1:0] scr_y,
    input  logic [23:0]      pix_in,
    output logic [23:0]      pix_out
);
    localparam int ROW_BYTES   = DIM / 8;
    localparam int PLANE_BYTES = DIM * ROW_BYTES;
    localparam int AW          = $clog2(2 * PLANE_BYTES);

    logic             ram_we;
    logic [AW-1:0]    ram_waddr;
    logic [7:0]       ram_wdata;
    logic             overlay_on;
    logic [POS_W-1:0] xpos, ypos;
    rgb_t             col_bg, col_fg;
    logic [AW-2:0]    plane_addr;
    logic [7:0]       src_byte, msk_byte;

    hcur_regs #(.POS_W(POS_W), .AW(AW)) u_regs (
        .clk, .rst, .host_we, .host_addr, .host_wdata,
        .ram_we, .ram_waddr, .ram_wdata, .overlay_on,
        .xpos, .ypos, .col_bg, .col_fg
    );

    hcur_ram #(.AW(AW)) u_ram (
        .clk, .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .plane_addr, .src_byte, .msk_byte
    );

    hcur_mix #(.POS_W(POS_W), .DIM(DIM), .AW(AW)) u_mix (
        .clk, .rst, .overlay_on, .xpos, .ypos, .col_bg, .col_fg,
        .scr_x, .scr_y, .pix_in, .plane_addr, .src_byte, .msk_byte, .pix_out
    );

endmodule

// File: tb/hcur_overlay_tb.sv
module hcur_overlay_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [11:0] scr_x = '0, scr_y = '0;
    logic [23:0] pix_in = '0;
    logic [23:0] pix_out;

    hcur_overlay u_dut (
        .clk, .rst, .host_we, .host_addr, .host_wdata,
        .scr_x, .scr_y, .pix_in, .pix_out
    );

    always #5 clk = ~clk;

    int    n_chk = 0, n_err = 0, cyc = 0;
    bit    chk_on = 1'b0, done = 1'b0;
    string tag = "R1";

    // Reference model state
    logic [7:0]  m_img [1024];
    int          m_mode, m_addr, m_x, m_y, m_cptr, m_cph;
    logic [23:0] m_bg, m_fg, exp_q;

    function automatic logic [23:0] ref_pix(int x, int y, logic [23:0] p);
        int c, r, bi, bt;
        if (m_mode != 3) return p;
        c = x - (m_x - 64);
        r = y - (m_y - 64);
        if (c < 0 || c > 63 || r < 0 || r > 63) return p;
        bi = r * 8 + c / 8;
        bt = 7 - (c % 8);
        if (!m_img[512 + bi][bt]) return p;
        return m_img[bi][bt] ? m_fg : m_bg;
    endfunction

    task automatic ref_write(int a, logic [7:0] d);
        case (a)
            0: m_addr = (m_addr & 'h300) | int'(d);
            1: begin m_mode = d & 3; m_addr = (((d >> 2) & 3) << 8) | (m_addr & 'hFF); end
            2: begin m_img[m_addr] = d; m_addr = (m_addr + 1) % 1024; end
            3: m_x = (m_x & 'hF00) | int'(d);
            4: m_x = (m_x & 'hFF) | ((d & 'hF) << 8);
            5: m_y = (m_y & 'hF00) | int'(d);
            6: m_y = (m_y & 'hFF) | ((d & 'hF) << 8);
            7: begin m_cptr = d & 3; m_cph = 0; end
            8: begin
                if (m_cptr == 1) m_bg[23 - 8*m_cph -: 8] = d;
                if (m_cptr == 2) m_fg[23 - 8*m_cph -: 8] = d;
                if (m_cph == 2) begin m_cph = 0; m_cptr = (m_cptr + 1) % 4; end
                else m_cph = m_cph + 1;
            end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            exp_q  <= '0;
            m_mode = 0; m_addr = 0; m_x = 0; m_y = 0; m_cptr = 0; m_cph = 0;
            m_bg = '0; m_fg = '0;
        end else begin
            exp_q <= ref_pix(int'(scr_x), int'(scr_y), pix_in);
            if (host_we) ref_write(int'(host_addr), host_wdata);
        end
    end

    // Compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            n_chk++;
            if (pix_out !== exp_q) begin
                n_err++;
                $display("FAIL %s cycle %0d: pix_out=%06h expected=%06h", tag, cyc, pix_out, exp_q);
            end
        end
    end

    task automatic hw(int a, int d);
        host_we = 1'b1; host_addr = 4'(a); host_wdata = 8'(d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic px(int x, int y);
        scr_x  = 12'(x);
        scr_y  = 12'(y);
        pix_in = {8'(x * 7 + 3) ^ 8'h5A, 8'(y * 5), 8'(cyc)};
        @(negedge clk);
    endtask

    task automatic sweep(int x0, int x1, int y0, int y1);
        for (int y = y0; y <= y1; y++)
            for (int x = x0; x <= x1; x++) px(x, y);
    endtask

    task automatic set_pos(int x, int y);
        hw(3, x & 255); hw(4, x >> 8); hw(5, y & 255); hw(6, y >> 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset value of the output
        n_chk++;
        if (pix_out !== 24'h0) begin
            n_err++;
            $display("FAIL R1: pix_out=%06h expected=000000", pix_out);
        end
        chk_on = 1'b1;

        tag = "R1"; sweep(0, 3, 0, 1);           // R1: mode off after reset
        tag = "R3"; sweep(10, 40, 5, 6);         // R3: one-cycle latency, changing pixels
        tag = "R9";                               // R9: colour load with auto-increment
        hw(7, 1);
        hw(8, 'h11); hw(8, 'h22); hw(8, 'h33);
        hw(8, 'hC4); hw(8, 'hD5); hw(8, 'hE6);
        tag = "R4";                               // R4: sequential image load from 0
        hw(0, 0); hw(1, 0);
        for (int i = 0; i < 512; i++) hw(2, (i * 37 + 5) & 255);
        for (int i = 0; i < 512; i++) hw(2, ((i * 11) ^ 'hC3) & 255);
        tag = "R2"; sweep(60, 120, 60, 62);      // R2: loaded but mode off
        set_pos(164, 114);
        hw(1, 3);
        tag = "R5"; sweep(90, 170, 45, 120);     // R5, R7, R8, R11: full window and border
        tag = "R6"; set_pos(10, 20);             // R6: partly off left and top
        sweep(0, 20, 0, 30);
        tag = "R10"; hw(1, 1); sweep(0, 12, 0, 4); // R10: mode 1 passes
        hw(1, 2); sweep(0, 12, 0, 4);              // R10: mode 2 passes
        tag = "R9"; hw(1, 3);                    // R9: rewrite foreground, spill to entry 3
        hw(7, 2);
        hw(8, 'h10); hw(8, 'h20); hw(8, 'h30);
        hw(8, 'hAA); hw(8, 'hBB); hw(8, 'hCC);
        sweep(0, 20, 0, 20);
        tag = "R4";                              // R4: carry from bit 7 into bit 8
        hw(0, 'hFF); hw(1, 'h07);
        hw(2, 'hFF); hw(2, 'h00); hw(2, 'hFF);
        sweep(0, 20, 0, 20);
        tag = "R7"; set_pos(4095, 4095);         // R7, R11: far corner placement
        sweep(4020, 4095, 4060, 4095);
        tag = "R11"; set_pos(64, 64); sweep(60, 70, 60, 70);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        while (cyc < 150000 && !done) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            n_err++; n_chk++;
            $display("FAIL watchdog: cycles=%0d expected=finish", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule